// File: doc/BRIEF.md
# TLP to 64-bit Stream Packer

This block turns one PCI Express transaction-layer packet at a time into beats of a 64-bit transmit stream. A descriptor announces each packet. It gives the header length (three or four dwords), bit 2 of the target address and the payload length in dwords. The header dwords and then the payload dwords follow on a 32-bit valid/ready input, one dword per transfer. Each output beat holds two 32-bit lanes. The earlier dword goes in bits [31:0] and the later dword in bits [63:32]. Start-of-packet and end-of-packet markers are driven with the beats, and a flag marks a final beat whose upper lane is unused.

The placement of payload follows the address. When bit 2 of the address is clear, payload dword 0 starts in the low lane. When it is set, payload dword 0 starts in the high lane. An empty slot is inserted after the header whenever the header length alone would put it in the wrong lane. Header dwords are re-ordered so that the first header byte sits in the most significant byte. Payload dwords pass through with their bytes unchanged.

The sequencing is done by a four-state machine:
- **IDLE** waits for a descriptor.
- **HDR** takes the header dwords.
- **PAD** emits the empty slot.
- **DATA** takes the payload.

It makes these transitions:
- IDLE goes to HDR when a descriptor is accepted.
- HDR goes to IDLE after the last header dword if there is no payload.
- HDR goes to PAD after the last header dword if a slot must be inserted.
- HDR goes to DATA otherwise.
- PAD always goes to DATA.
- DATA goes to IDLE after the last payload dword.

A lane assembler behind the state machine pairs the dwords into beats and holds the output register.

Top module: `tlp_stream_packer`

## Requirements
- R1: Each beat carries the earlier dword in bits [31:0] and the later dword in bits [63:32]. The first beat of every packet carries header dword 0 low and header dword 1 high.
- R2: Input dwords carry byte k in bits [8k+7:8k]. Every header dword is output byte-reversed, so header byte 0 appears in bits [31:24] and byte 3 in bits [7:0].
- R3: Payload dwords are output with byte order unchanged, so payload byte 0 stays in bits [7:0].
- R4: With a 3-dword header and address bit 2 set, beat 2 is {payload 0, header 2}. Later beats carry payload dwords 1 and 2, low then high, and so on.
- R5: With a 3-dword header and address bit 2 clear, beat 2 is {32'h0, header 2}. Payload dword 0 is in the low lane of beat 3.
- R6: With a 4-dword header and address bit 2 clear, beat 2 is {header 3, header 2}. Beat 3 is {payload 1, payload 0}.
- R7: With a 4-dword header and address bit 2 set, beat 3 is {payload 0, 32'h0}. Payload dword 1 is in the low lane of beat 4.
- R8: out_sop is 1 only on the first beat of a packet, and out_eop is 1 only on its last beat.
- R9: When the last beat uses only the low lane, out_empty is 1 and bits [63:32] are zero. On every other beat out_empty is 0.
- R10: A packet with a payload length of 0 ends with out_eop on the beat that carries its last header dword.
- R11: While out_valid is 1 and out_ready is 0, the output beat and its flags hold. No dword is lost or duplicated under output back-pressure or input gaps.
- R12: After reset, out_valid is 0, desc_ready is 1 and in_ready is 0.
- R13: desc_ready is 0 from the acceptance of a descriptor until the last dword of that packet is taken, and in_ready is 0 whenever desc_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted when high with desc_valid |
| desc_hdr4 | input | 1 | 1: four-dword header, 0: three-dword header |
| desc_addr_b2 | input | 1 | Bit 2 of the target address (1: not qword aligned) |
| desc_len | input | LEN_W | Payload length in dwords (0: no payload) |
| in_valid | input | 1 | Input dword offered |
| in_ready | output | 1 | Input dword taken when high with in_valid |
| in_dword | input | 32 | Header then payload dwords, byte k in bits [8k+7:8k] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 64 | Beat data, earlier dword low |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_empty | output | 1 | Upper lane of the last beat unused |

## Verification
All four combinations of header length and address bit 2 are sent with short payloads. Each combination is the only one that can place the empty slot where it belongs or show that no slot is needed. Packets without payload of both header lengths separate the eop-on-header rule from the padding logic, and odd payload lengths separate a half-filled last beat from a full one. A longer packet, sent under an irregular downstream ready pattern and with gaps on the input, tells a correct hold from a lost or duplicated dword.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;
    localparam int DW = 32;
    localparam int BEAT_W = 2 * DW;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAD,
        ST_DATA
    } seq_state_e;

    // Reverse the four bytes of a dword.
    function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction
endpackage

// File: rtl/tlp_pack_seq.sv
module tlp_pack_seq
    import tlp_pack_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic             desc_hdr4,
    input  logic             desc_addr_b2,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_dword,
    output logic             slot_valid,
    output logic [DW-1:0]    slot_dword,
    output logic             slot_last,
    output logic             slot_first,
    input  logic             slot_room
);
    seq_state_e       state, nxt;
    logic             hdr4_q;
    logic             pad_q;
    logic [1:0]       hdr_idx;
    logic [LEN_W-1:0] remain;
    logic             is_in;
    logic             hdr_end;
    logic             adv;

    assign hdr_end  = (hdr_idx == (hdr4_q ? 2'd3 : 2'd2));
    assign adv      = slot_valid && slot_room;
    assign in_ready = is_in && slot_room;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (desc_valid) nxt = ST_HDR;
            ST_HDR: begin
                if (adv && hdr_end) begin
                    if (remain == '0) nxt = ST_IDLE;
                    else if (pad_q)   nxt = ST_PAD;
                    else              nxt = ST_DATA;
                end
            end
            ST_PAD:  if (adv) nxt = ST_DATA;
            ST_DATA: if (adv && remain == LEN_W'(1)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        desc_ready = 1'b0;
        is_in      = 1'b0;
        slot_valid = 1'b0;
        slot_dword = '0;
        slot_last  = 1'b0;
        slot_first = 1'b0;
        unique case (state)
            ST_IDLE: desc_ready = 1'b1;
            ST_HDR: begin
                is_in      = 1'b1;
                slot_valid = in_valid;
                slot_dword = swap_bytes(in_dword);
                slot_last  = hdr_end && (remain == '0);
                slot_first = (hdr_idx == 2'd0);
            end
            ST_PAD: slot_valid = 1'b1;
            ST_DATA: begin
                is_in      = 1'b1;
                slot_valid = in_valid;
                slot_dword = in_dword;
                slot_last  = (remain == LEN_W'(1));
            end
            default: ;
        endcase
    end

    // per-packet counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr4_q  <= 1'b0;
            pad_q   <= 1'b0;
            hdr_idx <= '0;
            remain  <= '0;
        end else begin
            if (state == ST_IDLE && desc_valid) begin
                hdr4_q  <= desc_hdr4;
                // a slot is inserted when header parity disagrees with the address lane
                pad_q   <= (desc_hdr4 == desc_addr_b2);
                hdr_idx <= '0;
                remain  <= desc_len;
            end
            if (state == ST_HDR && adv)  hdr_idx <= hdr_idx + 2'd1;
            if (state == ST_DATA && adv) remain  <= remain - LEN_W'(1);
        end
    end
endmodule

// File: rtl/tlp_pack_asm.sv
module tlp_pack_asm
    import tlp_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid,
    input  logic [DW-1:0]     slot_dword,
    input  logic              slot_last,
    input  logic              slot_first,
    output logic              slot_room,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_empty
);
    logic          lane_hi;
    logic [DW-1:0] lo_q;
    logic          lo_sop;
    logic          out_free;
    logic          take;
    logic          emit;

    assign out_free  = !out_valid || out_ready;
    assign slot_room = (!lane_hi && !slot_last) || out_free;
    assign take      = slot_valid && slot_room;
    assign emit      = take && (lane_hi || slot_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_hi   <= 1'b0;
            lo_q      <= '0;
            lo_sop    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_empty <= 1'b0;
        end else begin
            if (take) lane_hi <= slot_last ? 1'b0 : !lane_hi;
            if (take && !lane_hi) begin
                lo_q   <= slot_dword;
                lo_sop <= slot_first;
            end
            if (emit) begin
                out_valid <= 1'b1;
                out_data  <= lane_hi ? {slot_dword, lo_q} : {{DW{1'b0}}, slot_dword};
                out_sop   <= lane_hi ? lo_sop : slot_first;
                out_eop   <= slot_last;
                out_empty <= !lane_hi;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tlp_stream_packer.sv
module tlp_stream_packer
    import tlp_pack_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic              desc_hdr4,
    input  logic              desc_addr_b2,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DW-1:0]     in_dword,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_empty
);
    logic          slot_valid;
    logic [DW-1:0] slot_dword;
    logic          slot_last;
    logic          slot_first;
    logic          slot_room;

    tlp_pack_seq #(.LEN_W(LEN_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_ready   (desc_ready),
        .desc_hdr4    (desc_hdr4),
        .desc_addr_b2 (desc_addr_b2),
        .desc_len     (desc_len),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_dword     (in_dword),
        .slot_valid   (slot_valid),
        .slot_dword   (slot_dword),
        .slot_last    (slot_last),
        .slot_first   (slot_first),
        .slot_room    (slot_room)
    );

    tlp_pack_asm u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_valid),
        .slot_dword (slot_dword),
        .slot_last  (slot_last),
        .slot_first (slot_first),
        .slot_room  (slot_room),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_empty  (out_empty)
    );
endmodule

// File: rtl/tlp_pack_chk.sv
module tlp_pack_chk
    import tlp_pack_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              desc_ready,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BEAT_W-1:0] out_data,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_empty
);
    logic in_pkt;

    always_ff @(posedge clk) begin
        if (!rst_n)                      in_pkt <= 1'b0;
        else if (out_valid && out_ready) in_pkt <= !out_eop;
    end

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
            && $stable(out_eop) && $stable(out_empty));

    a_r9_empty_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_eop);

    a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_empty |-> out_data[BEAT_W-1:DW] == '0);

    a_r8_sop_first: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !in_pkt |-> out_sop);

    a_r8_sop_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && in_pkt |-> !out_sop);

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !in_ready);
endmodule

bind tlp_stream_packer tlp_pack_chk u_chk (.*);

// File: tb/tb_tlp_stream_packer.sv
module tb_tlp_stream_packer;
    localparam int LEN_W = 10;
    localparam int WD_LIMIT = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             desc_valid = 1'b0;
    logic             desc_ready;
    logic             desc_hdr4 = 1'b0;
    logic             desc_addr_b2 = 1'b0;
    logic [LEN_W-1:0] desc_len = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [31:0]      in_dword = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [63:0]      out_data;
    logic             out_sop;
    logic             out_eop;
    logic             out_empty;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic [31:0] slots [0:63];
    int          ns;
    logic [63:0] exp_d [0:31];
    logic        exp_s [0:31];
    logic        exp_e [0:31];
    logic        exp_m [0:31];
    int          exp_n;
    logic [63:0] got_d [0:31];
    logic        got_s [0:31];
    logic        got_e [0:31];
    logic        got_m [0:31];
    int          got_n;

    tlp_stream_packer #(.LEN_W(LEN_W)) dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] hdr_in(input int i);
        logic [7:0] b0 = 8'(16 * (i + 1));
        return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
    endfunction

    function automatic logic [31:0] pay_in(input int j);
        logic [7:0] b0 = 8'(8'h80 + 4 * j);
        return {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0};
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic build(input bit hdr4, input bit a2, input int len);
        int hc = hdr4 ? 4 : 3;
        ns = 0;
        for (int i = 0; i < hc; i++) begin slots[ns] = rev(hdr_in(i)); ns++; end
        if (len > 0 && hdr4 == a2) begin slots[ns] = 32'h0; ns++; end
        for (int j = 0; j < len; j++) begin slots[ns] = pay_in(j); ns++; end
        exp_n = (ns + 1) / 2;
        for (int b = 0; b < exp_n; b++) begin
            exp_m[b] = (2 * b + 1 >= ns);
            exp_d[b] = {exp_m[b] ? 32'h0 : slots[2 * b + 1], slots[2 * b]};
            exp_s[b] = (b == 0);
            exp_e[b] = (b == exp_n - 1);
        end
    endtask

    task automatic drive(input bit hdr4, input bit a2, input int len, input bit gaps);
        int hc = hdr4 ? 4 : 3;
        @(negedge clk);
        desc_valid = 1'b1; desc_hdr4 = hdr4; desc_addr_b2 = a2; desc_len = LEN_W'(len);
        #1;
        while (!desc_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        desc_valid = 1'b0;
        #1;
        check(desc_ready == 1'b0, "R13 desc_ready during packet", 64'(desc_ready), 64'(0));
        for (int k = 0; k < hc + len; k++) begin
            if (gaps && (k % 2 == 1)) begin in_valid = 1'b0; @(negedge clk); end
            in_valid = 1'b1;
            in_dword = (k < hc) ? hdr_in(k) : pay_in(k - hc);
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic collect(input logic [7:0] pat);
        int cyc = 0;
        got_n = 0;
        while (got_n < exp_n) begin
            @(negedge clk);
            out_ready = pat[cyc % 8];
            cyc++;
            #1;
            if (out_valid && out_ready) begin
                got_d[got_n] = out_data; got_s[got_n] = out_sop;
                got_e[got_n] = out_eop;  got_m[got_n] = out_empty;
                got_n++;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic run_pkt(input string tag, input bit hdr4, input bit a2, input int len,
                           input logic [7:0] pat, input bit gaps);
        build(hdr4, a2, len);
        fork
            drive(hdr4, a2, len, gaps);
            collect(pat);
        join
        for (int b = 0; b < exp_n; b++) begin
            check(got_d[b] == exp_d[b], $sformatf("%s beat %0d data", tag, b), got_d[b], exp_d[b]);
            check(got_s[b] == exp_s[b] && got_e[b] == exp_e[b], $sformatf("R8 %s beat %0d sop/eop", tag, b),
                  {62'h0, got_s[b], got_e[b]}, {62'h0, exp_s[b], exp_e[b]});
            check(got_m[b] == exp_m[b], $sformatf("R9 %s beat %0d empty", tag, b),
                  64'(got_m[b]), 64'(exp_m[b]));
        end
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R12 out_valid after reset", 64'(out_valid), 64'(0));
        check(desc_ready == 1'b1, "R12 desc_ready after reset", 64'(desc_ready), 64'(1));
        check(in_ready == 1'b0, "R12 in_ready after reset", 64'(in_ready), 64'(0));
    endtask

    task automatic t_hdr3_unaligned();
        run_pkt("R4 hdr3 addr2=1", 1'b0, 1'b1, 3, 8'hFF, 1'b0);
        check(got_d[0] == {rev(hdr_in(1)), rev(hdr_in(0))} && got_s[0], "R1 first beat lanes",
              got_d[0], {rev(hdr_in(1)), rev(hdr_in(0))});
        check(got_d[0][31:24] == 8'h10, "R2 header byte0 in [31:24]", 64'(got_d[0][31:24]), 64'h10);
        check(got_d[1][39:32] == 8'h80, "R3 payload byte0 in [7:0]", 64'(got_d[1][39:32]), 64'h80);
    endtask

    task automatic t_hdr3_aligned();
        run_pkt("R5 hdr3 addr2=0", 1'b0, 1'b0, 3, 8'hFF, 1'b0);
    endtask

    task automatic t_hdr4_aligned();
        run_pkt("R6 hdr4 addr2=0", 1'b1, 1'b0, 2, 8'hFF, 1'b0);
    endtask

    task automatic t_hdr4_unaligned();
        run_pkt("R7 hdr4 addr2=1", 1'b1, 1'b1, 1, 8'hFF, 1'b0);
    endtask

    task automatic t_no_payload();
        run_pkt("R10 hdr3 len0", 1'b0, 1'b0, 0, 8'hFF, 1'b0);
        run_pkt("R10 hdr4 len0", 1'b1, 1'b1, 0, 8'hFF, 1'b0);
    endtask

    task automatic t_backpressure();
        run_pkt("R11 hdr4 stall", 1'b1, 1'b0, 7, 8'b0110_0101, 1'b1);
        run_pkt("R11 hdr3 stall", 1'b0, 1'b1, 6, 8'b1000_1001, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_hdr3_unaligned();
        t_hdr3_aligned();
        t_hdr4_aligned();
        t_hdr4_unaligned();
        t_no_payload();
        t_backpressure();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule